// File: doc/BRIEF.md
# Sector DMA Transfer Engine

This block copies one 512-byte sector, 128 words of 32 bits, out of a one-word-wide cache on the disk controller and into a sixteen-word-wide main memory. Three stages run side by side. The first reads the cache one word at a time and packs four words into a staging register. The second carries each four-word group across the bus as one beat, and the bus stays occupied for four cycles per beat. The third gathers four beats into a sixteen-word line and issues it as one wide memory write. That write takes 80 cycles, and the next write cannot be issued until it finishes.

The memory side has two line buffers, so the next line can be assembled while a write is in progress. The bus stops launching beats only when both line buffers are full or already claimed by beats in flight. Memory is the slowest stage and sets the pace. The total time is reported on a cycle counter, so it can be compared with the figure worked out on paper.

To use the block, place a line-aligned destination address on `dst_base` and pulse `start`. Then wait for the one-cycle `done` pulse and read `cycle_count`.

Top module: `sector_dma_engine`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `cache_rd_en` and `mem_wr_en` are low and `cycle_count` is 0.
- R2: A `start` pulse while idle latches `dst_base` and raises `busy`. Cache reads then cover addresses 0 to 127 in ascending order, each exactly once, and no read is made while the block is idle.
- R3: Cache read data is taken as valid exactly one cycle after the cycle in which `cache_rd_en` was high.
- R4: Memory line k (k from 0 to 7) carries cache word 16k+j in bit lanes [32j+31:32j] of `mem_wr_data`, for j from 0 to 15.
- R5: Write k goes to word address `dst_base` + 16k. `dst_base` must be a multiple of 16. No word outside `dst_base` to `dst_base`+127 is written.
- R6: Any two memory writes are at least 80 cycles apart, so only one write is in progress at a time.
- R7: A transfer issues exactly 8 memory writes.
- R8: `done` is high for exactly one cycle, at the edge where the last write completes. `busy` falls at that same edge.
- R9: `cycle_count` counts the clock edges from the edge that accepts `start` to the edge that raises `done`. With the default parameters this is 673, which is no less than 640 (eight back-to-back 80-cycle writes). The value holds until the next accepted start.
- R10: A `start` pulse while `busy` is high is ignored. The running transfer keeps its address, its contents and its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | One-cycle request to begin a transfer |
| dst_base | input | 32 | Destination word address, a multiple of 16 |
| busy | output | 1 | High while a transfer runs |
| done | output | 1 | One-cycle pulse at the end of the transfer |
| cycle_count | output | 16 | Length of the last transfer in cycles |
| cache_rd_en | output | 1 | Cache read strobe |
| cache_rd_addr | output | 7 | Cache word address |
| cache_rd_data | input | 32 | Cache word, valid one cycle after the strobe |
| mem_wr_en | output | 1 | One-cycle pulse that issues a line write |
| mem_wr_addr | output | 32 | Word address of the line being written |
| mem_wr_data | output | 512 | Sixteen-word line, held until the write completes |

## Verification
The checker relies on two conditions at the inputs. The destination base is a multiple of sixteen, which is what makes every write address line-aligned. The cache answers a read with the stored word on the following cycle. The bench keeps within both. Every base it sweeps is a multiple of sixteen, and its cache model latches each request at the falling edge and returns the word at the next rising edge. The bench also sends a stray start pulse in the middle of a transfer. That pulse is legal input, and the bench observes that the pulse changes nothing.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  // Transfer controller state
  typedef enum logic {
    XF_IDLE = 1'b0,
    XF_RUN  = 1'b1
  } xfer_state_e;

endpackage

// File: rtl/sdma_fetch.sv
// Reads the narrow cache one word per cycle and packs a bus beat.
module sdma_fetch #(
  parameter  int WORD_W      = 32,
  parameter  int BEAT_WORDS  = 4,
  parameter  int TOTAL_WORDS = 128,
  localparam int AW          = $clog2(TOTAL_WORDS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         run,
  input  logic                         beat_take,
  output logic                         rd_en,
  output logic [AW-1:0]                rd_addr,
  input  logic [WORD_W-1:0]            rd_data,
  output logic                         beat_valid,
  output logic [BEAT_WORDS*WORD_W-1:0] beat_data
);

  localparam int CW = $clog2(BEAT_WORDS + 1);
  localparam int FW = CW + 1;
  localparam int IW = AW + 1;

  logic [IW-1:0] idx_q, idx_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic [FW-1:0] fill;
  logic [BEAT_WORDS-1:0][WORD_W-1:0] stg_q, stg_d;
  logic          stg_en;

  always_comb begin
    fill       = FW'(cnt_q) + FW'(pend_q);
    beat_valid = (cnt_q == CW'(BEAT_WORDS));
    rd_en      = run && (idx_q < IW'(TOTAL_WORDS)) &&
                 ((fill < FW'(BEAT_WORDS)) || beat_take);
    rd_addr    = idx_q[AW-1:0];
    beat_data  = stg_q;
    stg_en     = pend_q;

    idx_d  = idx_q;
    cnt_d  = cnt_q;
    pend_d = rd_en;
    stg_d  = stg_q;
    if (rd_en) idx_d = idx_q + IW'(1);
    if (pend_q) begin
      for (int w = 0; w < BEAT_WORDS; w++) begin
        if (cnt_q == CW'(w)) stg_d[w] = rd_data;
      end
      cnt_d = cnt_q + CW'(1);
    end
    if (beat_take) cnt_d = '0;
    if (clr) begin
      idx_d  = '0;
      cnt_d  = '0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (stg_en) stg_q <= stg_d;
  end

endmodule

// File: rtl/sdma_bus_stage.sv
// Non-pipelined bus: one beat occupies it for LAT cycles.
module sdma_bus_stage #(
  parameter  int DATA_W = 128,
  parameter  int LAT    = 4,
  localparam int TW     = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              ready,
  output logic              arrive,
  output logic [DATA_W-1:0] arrive_data
);

  logic          valid_q, valid_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    arrive      = valid_q && (tmr_q == '0);
    ready       = !valid_q || arrive;
    arrive_data = data_q;
    valid_d     = load ? 1'b1 : (arrive ? 1'b0 : valid_q);
    if (load)                   tmr_d = TW'(LAT - 1);
    else if (valid_q && !arrive) tmr_d = tmr_q - TW'(1);
    else                         tmr_d = tmr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tmr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      tmr_q   <= tmr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) data_q <= load_data;
  end

endmodule

// File: rtl/sdma_line_asm.sv
// Double-buffered line assembly and non-pipelined wide memory writer.
module sdma_line_asm #(
  parameter  int WORD_W     = 32,
  parameter  int BEAT_WORDS = 4,
  parameter  int LINE_BEATS = 4,
  parameter  int MEM_LAT    = 80,
  parameter  int ADDR_W     = 32,
  parameter  int NUM_LINES  = 8,
  localparam int BEAT_W     = WORD_W * BEAT_WORDS,
  localparam int LINE_W     = BEAT_W * LINE_BEATS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [ADDR_W-1:0] base,
  input  logic              beat_in,
  input  logic [BEAT_W-1:0] beat_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [LINE_W-1:0] mem_wr_data,
  output logic              line_free,
  output logic              all_done
);

  localparam int LINE_WORDS = BEAT_WORDS * LINE_BEATS;
  localparam int BIW        = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;
  localparam int MW         = $clog2(MEM_LAT);
  localparam int LNW        = $clog2(NUM_LINES + 1);

  logic              wsel_q, wsel_d, rsel_q, rsel_d;
  logic [BIW-1:0]    bidx_q, bidx_d;
  logic [1:0]        full_q, full_d;
  logic              act_q, act_d;
  logic [MW-1:0]     tmr_q, tmr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LNW-1:0]    lines_q, lines_d;
  logic              fill_last, wr_done;
  logic [1:0][LINE_W-1:0] lines_all;

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [LINE_BEATS-1:0][BEAT_W-1:0] line_q;
    always_ff @(posedge clk) begin
      for (int s = 0; s < LINE_BEATS; s++) begin
        if (beat_in && (wsel_q == 1'(b)) && (bidx_q == BIW'(s))) line_q[s] <= beat_data;
      end
    end
    assign lines_all[b] = line_q;
  end

  always_comb begin
    mem_wr_en   = full_q[rsel_q] && !act_q;
    mem_wr_addr = addr_q;
    mem_wr_data = lines_all[rsel_q];
    wr_done     = act_q && (tmr_q == '0);
    fill_last   = beat_in && (bidx_q == BIW'(LINE_BEATS - 1));
    line_free   = wr_done;
    all_done    = wr_done && (lines_q == LNW'(NUM_LINES - 1));

    wsel_d  = fill_last ? ~wsel_q : wsel_q;
    bidx_d  = beat_in ? (fill_last ? '0 : bidx_q + BIW'(1)) : bidx_q;
    full_d  = full_q;
    if (wr_done)   full_d[rsel_q] = 1'b0;
    if (fill_last) full_d[wsel_q] = 1'b1;
    act_d   = mem_wr_en ? 1'b1 : (wr_done ? 1'b0 : act_q);
    if (mem_wr_en)              tmr_d = MW'(MEM_LAT - 1);
    else if (act_q && !wr_done) tmr_d = tmr_q - MW'(1);
    else                        tmr_d = tmr_q;
    rsel_d  = wr_done ? ~rsel_q : rsel_q;
    addr_d  = wr_done ? addr_q + ADDR_W'(LINE_WORDS) : addr_q;
    lines_d = wr_done ? lines_q + LNW'(1) : lines_q;
    if (clr) begin
      wsel_d  = 1'b0;
      rsel_d  = 1'b0;
      bidx_d  = '0;
      full_d  = '0;
      act_d   = 1'b0;
      tmr_d   = '0;
      addr_d  = base;
      lines_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel_q  <= 1'b0;
      rsel_q  <= 1'b0;
      bidx_q  <= '0;
      full_q  <= '0;
      act_q   <= 1'b0;
      tmr_q   <= '0;
      addr_q  <= '0;
      lines_q <= '0;
    end else begin
      wsel_q  <= wsel_d;
      rsel_q  <= rsel_d;
      bidx_q  <= bidx_d;
      full_q  <= full_d;
      act_q   <= act_d;
      tmr_q   <= tmr_d;
      addr_q  <= addr_d;
      lines_q <= lines_d;
    end
  end

endmodule

// File: rtl/sector_dma_engine.sv
module sector_dma_engine #(
  parameter  int WORD_W       = 32,
  parameter  int SECTOR_WORDS = 128,
  parameter  int BEAT_WORDS   = 4,
  parameter  int LINE_BEATS   = 4,
  parameter  int BUS_LAT      = 4,
  parameter  int MEM_LAT      = 80,
  parameter  int ADDR_W       = 32,
  parameter  int CNT_W        = 16,
  localparam int AW           = $clog2(SECTOR_WORDS),
  localparam int LINE_W       = WORD_W * BEAT_WORDS * LINE_BEATS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] dst_base,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  cycle_count,
  output logic              cache_rd_en,
  output logic [AW-1:0]     cache_rd_addr,
  input  logic [WORD_W-1:0] cache_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [LINE_W-1:0] mem_wr_data
);

  import sdma_pkg::*;

  localparam int LINE_WORDS = BEAT_WORDS * LINE_BEATS;
  localparam int NUM_LINES  = SECTOR_WORDS / LINE_WORDS;
  localparam int BEAT_W     = WORD_W * BEAT_WORDS;
  localparam int SLOTS      = 2 * LINE_BEATS;
  localparam int RW         = $clog2(SLOTS + 1);

  logic [1:0]   rsync_q;
  logic         rst_int_n;
  xfer_state_e  state_q, state_d;
  logic [RW-1:0] resv_q, resv_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic         cnt_en, done_q, done_d;
  logic         start_acc, launch;
  logic         beat_valid, bus_ready, arrive, line_free, all_done;
  logic [BEAT_W-1:0] beat_data, arrive_data;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  always_comb begin
    busy      = (state_q == XF_RUN);
    start_acc = start && (state_q == XF_IDLE);
    launch    = beat_valid && bus_ready && (resv_q < RW'(SLOTS));
    resv_d    = resv_q + (launch ? RW'(1) : RW'(0)) - (line_free ? RW'(LINE_BEATS) : RW'(0));
    if (start_acc) resv_d = '0;
    state_d   = state_q;
    if (start_acc)     state_d = XF_RUN;
    else if (all_done) state_d = XF_IDLE;
    cnt_en    = start_acc || busy;
    cnt_d     = start_acc ? '0 : cnt_q + CNT_W'(1);
    done_d    = all_done;
    done        = done_q;
    cycle_count = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= XF_IDLE;
      resv_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      resv_q  <= resv_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  sdma_fetch #(
    .WORD_W(WORD_W), .BEAT_WORDS(BEAT_WORDS), .TOTAL_WORDS(SECTOR_WORDS)
  ) u_fetch (
    .clk(clk), .rst_n(rst_int_n), .clr(start_acc), .run(busy),
    .beat_take(launch), .rd_en(cache_rd_en), .rd_addr(cache_rd_addr),
    .rd_data(cache_rd_data), .beat_valid(beat_valid), .beat_data(beat_data)
  );

  sdma_bus_stage #(
    .DATA_W(BEAT_W), .LAT(BUS_LAT)
  ) u_bus (
    .clk(clk), .rst_n(rst_int_n), .load(launch), .load_data(beat_data),
    .ready(bus_ready), .arrive(arrive), .arrive_data(arrive_data)
  );

  sdma_line_asm #(
    .WORD_W(WORD_W), .BEAT_WORDS(BEAT_WORDS), .LINE_BEATS(LINE_BEATS),
    .MEM_LAT(MEM_LAT), .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)
  ) u_asm (
    .clk(clk), .rst_n(rst_int_n), .clr(start_acc), .base(dst_base),
    .beat_in(arrive), .beat_data(arrive_data), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .line_free(line_free), .all_done(all_done)
  );

endmodule

// File: rtl/sdma_checker.sv
module sdma_checker #(
  parameter int AW         = 7,
  parameter int ADDR_W     = 32,
  parameter int MEM_LAT    = 80,
  parameter int NUM_LINES  = 8,
  parameter int LINE_WORDS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              cache_rd_en,
  input logic [AW-1:0]     cache_rd_addr,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_wr_addr
);

  localparam int GW  = $clog2(MEM_LAT + 2) + 1;
  localparam int LWB = $clog2(LINE_WORDS);
  localparam int NW  = $clog2(NUM_LINES + 2);

  logic [GW-1:0] gap_q;
  logic [AW:0]   rd_seen_q;
  logic [NW-1:0] wr_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= GW'(MEM_LAT + 1);
      rd_seen_q <= '0;
      wr_seen_q <= '0;
    end else begin
      if (mem_wr_en)                     gap_q <= GW'(1);
      else if (gap_q < GW'(MEM_LAT + 1)) gap_q <= gap_q + GW'(1);
      if (!busy)            rd_seen_q <= '0;
      else if (cache_rd_en) rd_seen_q <= rd_seen_q + 1'b1;
      if (!busy)          wr_seen_q <= '0;
      else if (mem_wr_en) wr_seen_q <= wr_seen_q + NW'(1);
    end
  end

  assert_rd_in_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cache_rd_en |-> busy);
  assert_rd_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cache_rd_en |-> ({1'b0, cache_rd_addr} == rd_seen_q));
  assert_line_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_wr_addr[LWB-1:0] == '0));
  assert_wr_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (gap_q >= GW'(MEM_LAT)));
  assert_wr_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (wr_seen_q < NW'(NUM_LINES)));
  assert_wr_total_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_seen_q == NW'(NUM_LINES)));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

bind sector_dma_engine sdma_checker #(
  .AW(AW), .ADDR_W(ADDR_W), .MEM_LAT(MEM_LAT),
  .NUM_LINES(SECTOR_WORDS / (BEAT_WORDS * LINE_BEATS)),
  .LINE_WORDS(BEAT_WORDS * LINE_BEATS)
) u_sdma_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .cache_rd_en(cache_rd_en), .cache_rd_addr(cache_rd_addr),
  .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr)
);

// File: tb/sector_dma_engine_bench.sv
`timescale 1ns/1ps
module sector_dma_engine_bench;

  localparam int WORDS    = 128;
  localparam int BEAT     = 4;
  localparam int LBEATS   = 4;
  localparam int BUSL     = 4;
  localparam int MEML     = 80;
  localparam int LWORDS   = BEAT * LBEATS;
  localparam int NLINES   = WORDS / LWORDS;
  localparam int MEMSZ    = 1024;
  // First line issue: first beat launch, fetch-limited beat period, bus, one cycle to issue
  localparam int FIRST_ISSUE = (BEAT + 2) + (BEAT + 1) * (LBEATS - 1) + BUSL + 1;
  localparam int EXP_CYC     = FIRST_ISSUE + (NLINES - 1) * (MEML + 1) + MEML;

  logic         clk, rst_n, start;
  logic [31:0]  dst_base;
  logic         busy, done;
  logic [15:0]  cycle_count;
  logic         cache_rd_en;
  logic [6:0]   cache_rd_addr;
  logic [31:0]  cache_rd_data;
  logic         mem_wr_en;
  logic [31:0]  mem_wr_addr;
  logic [511:0] mem_wr_data;

  sector_dma_engine u_sector_dma_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_base(dst_base),
    .busy(busy), .done(done), .cycle_count(cycle_count),
    .cache_rd_en(cache_rd_en), .cache_rd_addr(cache_rd_addr),
    .cache_rd_data(cache_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] cache_mem [WORDS];
  logic [31:0] dmem [MEMSZ];
  logic        rq_en;
  logic [6:0]  rq_addr;
  int          rd_expect, rd_bad, rd_total;
  int          wr_total, addr_bad, gap_min, last_issue, cyc;
  logic [31:0] run_base;

  function automatic logic [31:0] pat(int seed, int i);
    return (32'(seed) * 32'h0100_0193) ^ (32'(i) * 32'h9E37_79B9) ^ {8'(i), 24'h00A5C3};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Cache model: request latched away from the edge, data returned on the next edge (R3)
  always @(negedge clk) begin
    rq_en   = cache_rd_en;
    rq_addr = cache_rd_addr;
    if (cache_rd_en) begin
      if (int'(cache_rd_addr) != rd_expect) rd_bad++;
      rd_expect++;
      rd_total++;
    end
    if (mem_wr_en) begin
      for (int j = 0; j < LWORDS; j++) begin
        if (int'(mem_wr_addr) + j < MEMSZ) dmem[int'(mem_wr_addr) + j] = mem_wr_data[32*j +: 32];
      end
      if (mem_wr_addr != run_base + 32'(LWORDS * wr_total)) addr_bad++;
      if (wr_total > 0 && (cyc - last_issue) < gap_min) gap_min = cyc - last_issue;
      last_issue = cyc;
      wr_total++;
    end
    cyc++;
  end
  always @(posedge clk) begin
    if (rq_en) cache_rd_data <= cache_mem[rq_addr];
  end

  task automatic run_xfer(input int base, input int seed, input bit stray_start);
    int k;
    bit timed_out;
    for (int i = 0; i < WORDS; i++) cache_mem[i] = pat(seed, i);
    for (int a = 0; a < MEMSZ; a++) dmem[a] = 32'hDEAD_0000 ^ 32'(a);
    rd_expect = 0; rd_bad = 0; rd_total = 0;
    wr_total = 0; addr_bad = 0; gap_min = 1_000_000;
    run_base = 32'(base);
    dst_base = 32'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    timed_out = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", 64'(busy), 64'd1);
    while (!done) begin
      if (stray_start && k == 300) begin
        dst_base = 32'(base + 32);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
      if (k > 5000) begin timed_out = 1'b1; break; end
    end
    start = 1'b0;
    dst_base = 32'(base);
    check(!timed_out, "R8", "done reached", 64'(k), 64'(EXP_CYC));
    check(k == EXP_CYC, "R9", "edges start to done", 64'(k), 64'(EXP_CYC));
    check(cycle_count == 16'(EXP_CYC), "R9", "cycle_count", 64'(cycle_count), 64'(EXP_CYC));
    check(k >= NLINES * MEML, "R9", "not faster than serial writes", 64'(k), 64'(NLINES * MEML));
    check(busy == 1'b0, "R8", "busy falls with done", 64'(busy), 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", 64'(done), 64'd0);
    check(rd_total == WORDS && rd_bad == 0, "R2", "read count/order",
          64'(rd_total) | (64'(rd_bad) << 32), 64'(WORDS));
    check(wr_total == NLINES, "R7", "write count", 64'(wr_total), 64'(NLINES));
    check(addr_bad == 0, stray_start ? "R10" : "R5", "write addresses", 64'(addr_bad), 64'd0);
    check(gap_min >= MEML, "R6", "min write spacing", 64'(gap_min), 64'(MEML));
    for (int i = 0; i < WORDS; i++)
      check(dmem[base + i] == pat(seed, i), "R4", "memory word", 64'(dmem[base + i]), 64'(pat(seed, i)));
    if (base > 0)
      check(dmem[base - 1] == (32'hDEAD_0000 ^ 32'(base - 1)), "R5", "word below untouched",
            64'(dmem[base - 1]), 64'(32'hDEAD_0000 ^ 32'(base - 1)));
    check(dmem[base + WORDS] == (32'hDEAD_0000 ^ 32'(base + WORDS)), "R5", "word above untouched",
          64'(dmem[base + WORDS]), 64'(32'hDEAD_0000 ^ 32'(base + WORDS)));
    repeat (5) @(negedge clk);
    check(cycle_count == 16'(EXP_CYC) && !busy && !cache_rd_en, "R9", "count held while idle",
          64'(cycle_count), 64'(EXP_CYC));
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc = 0;
    rq_en = 1'b0;
    rq_addr = '0;
    cache_rd_data = '0;
    run_base = '0;
    start = 1'b0;
    dst_base = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !cache_rd_en && !mem_wr_en && cycle_count == 0, "R1",
          "outputs in reset", {busy, done, cache_rd_en, mem_wr_en, 12'h0, cycle_count}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !cache_rd_en && !mem_wr_en && cycle_count == 0, "R1",
          "outputs after reset", {busy, done, cache_rd_en, mem_wr_en, 12'h0, cycle_count}, 64'd0);
    run_xfer(0, 1, 1'b0);
    run_xfer(16 * 5, 7, 1'b1);   // R10: stray start mid-transfer
    run_xfer(16 * 40, 12345, 1'b0);
    run_xfer(16 * 17, 99, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule